// File: doc/BRIEF.md
# Folded Up-Down Sequence Counter

This block is a 5-bit synchronous counter whose cycle is folded in half. From zero it rises one step per clock to 15. On the next clock it jumps to 31 and then falls one step per clock to 16. After 16 it returns to zero. The cycle is 32 states long, and every 5-bit code appears exactly once in it.

The interface has a positive-edge clock, a synchronous active-high reset and the count output. The block has no asynchronous initialisation, so its state after power-up is undefined. The user must assert reset at least once before relying on the output. Reset has priority over counting on any edge where both apply.

Top module: `fold_seq_counter`

## Requirements
- R1: The count output `cnt_o` is 5 bits wide, and its value is the current counter state.
- R2: On a rising clock edge with `rst_i` high, the state becomes 0, whatever its value before. Reset acts on clock edges only.
- R3: With reset low and a state from 0 to 14, the next state is the current state plus one.
- R4: With reset low and a state of 15, the next state is 31.
- R5: With reset low and a state from 17 to 31, the next state is the current state minus one.
- R6: With reset low and a state of 16, the next state is 0. The 32-state cycle then repeats without end.
- R7: Each of the 32 codes appears exactly once in every period of 32 clocks after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| cnt_o | output | 5 | Current count value |

## Verification
The count is held in a single register, so every result is due one clock edge after the stimulus. After a reset edge the output reads 0. After each later edge it shows the next value in the folded cycle. The bench drives its inputs and samples `cnt_o` on the falling clock edge, half a period after each rising edge. Each sample is compared with the table entry for the number of rising edges since reset was released. Directed tests apply reset at the fold points 15, 16 and 31, and also in the middle of each half. In every case the bench checks the single edge after reset is asserted.

// File: rtl/fold_seq_counter.sv
module fold_seq_counter #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] LoTop = (W)'((1 << (W-1)) - 1);
  localparam logic [W-1:0] HiBot = (W)'(1 << (W-1));
  localparam logic [W-1:0] AllOn = '1;

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         upper;

  assign upper = state_q[W-1];

  always_comb begin
    if (state_q == LoTop)      state_d = AllOn;
    else if (state_q == HiBot) state_d = '0;
    else if (upper)            state_d = state_q - 1'b1;
    else                       state_d = state_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= '0;
    else       state_q <= state_d;
  end

  assign cnt_o = state_q;

  logic armed_q = 1'b0;
  always_ff @(posedge clk_i) if (rst_i) armed_q <= 1'b1;

  p_reset_zero_r2: assert property (@(posedge clk_i)
    $past(rst_i) |-> cnt_o == '0);

  p_step_up_r3: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    (!cnt_o[W-1] && cnt_o != LoTop) |=> ($past(rst_i) || cnt_o == $past(cnt_o) + 1'b1));

  p_leap_top_r4: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    (cnt_o == LoTop) |=> ($past(rst_i) || cnt_o == AllOn));

  p_step_down_r5: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    (cnt_o[W-1] && cnt_o != HiBot) |=> ($past(rst_i) || cnt_o == $past(cnt_o) - 1'b1));

  p_wrap_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
    (cnt_o == HiBot) |=> ($past(rst_i) || cnt_o == '0));

endmodule

// File: tb/test_fold_seq_counter.sv
module test_fold_seq_counter;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [4:0] cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  fold_seq_counter #(.W(5)) i_fold_seq_counter (
    .clk_i(clk_i), .rst_i(rst_i), .cnt_o(cnt_o)
  );

  localparam logic [4:0] SEQ [32] = '{
    5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
    5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd14, 5'd15,
    5'd31, 5'd30, 5'd29, 5'd28, 5'd27, 5'd26, 5'd25, 5'd24,
    5'd23, 5'd22, 5'd21, 5'd20, 5'd19, 5'd18, 5'd17, 5'd16
  };

  task automatic check(input string req, input logic [4:0] exp);
    checks++;
    if (cnt_o !== exp) begin
      fails++;
      $display("FAIL %s: cnt_o=%0d expected %0d", req, cnt_o, exp);
    end
  endtask

  task automatic edge_step(input logic r);
    rst_i = r;
    @(negedge clk_i);
  endtask

  task automatic reset_at(input int pos, input string tag);
    edge_step(1'b1);
    for (int i = 0; i < pos; i++) edge_step(1'b0);
    check(tag, SEQ[pos]);
    edge_step(1'b1);
    check("R2 reset at position", 5'd0);
  endtask

  initial begin
    @(negedge clk_i);
    edge_step(1'b1);
    check("R2 reset state", 5'd0);
    check("R1 width/value", 5'd0);

    begin
      bit [31:0] seen;
      for (int p = 0; p < 3; p++) begin
        seen = '0;
        for (int k = 1; k <= 32; k++) begin
          edge_step(1'b0);
          if (SEQ[k % 32] == 5'd31)      check("R4 leap to 31", SEQ[k % 32]);
          else if (SEQ[k % 32] == 5'd0)  check("R6 wrap to 0", SEQ[k % 32]);
          else if (SEQ[k % 32] < 5'd16)  check("R3 count up", SEQ[k % 32]);
          else                           check("R5 count down", SEQ[k % 32]);
          seen[cnt_o] = 1'b1;
        end
        checks++;
        if (seen != '1) begin
          fails++;
          $display("FAIL R7: codes seen=%h expected ffffffff", seen);
        end
      end
    end

    reset_at(15, "R4 before reset");
    reset_at(16, "R4 at 31");
    reset_at(31, "R6 at 16");
    reset_at(7,  "R3 mid-low");
    reset_at(24, "R5 mid-high");

    edge_step(1'b0);
    check("R3 after reset", 5'd1);
    edge_step(1'b0);
    check("R3 second step", 5'd2);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule